// File: doc/BRIEF.md
# Host POST-Code Capture FIFO

This block snoops host I/O writes aimed at the debug port address. It stores every byte that the host writes there in a 32-entry queue of 16-bit records, so that local firmware can drain the queue later. Writes of one, two or four bytes are accepted. A multi-byte write becomes one record per byte. Each record carries the byte itself, the lane it arrived on, a code that gives its place within the write, and a copy of the status bits as they stood when the write arrived.

On the local side, the head record is always visible on `dattr`, and a one-cycle `rd_en` pops it. A three-bit status word reports not-empty, a sticky overrun flag and a fill-level flag. A level-sensitive interrupt requests service while the fill level is at or above a programmable threshold.

Top module: `postcode_fifo`

## Requirements
- R1: Each record is laid out as follows: bits [7:0] are the data byte, [9:8] the lane index (0 to 3), [11:10] the sequence code, [14:12] the status snapshot, and bit 15 is always 0.
- R2: A write is captured only when `host_wr` is 1 and `host_addr[15:2]` equals `BASE[15:2]` (default BASE 16'h0080). Writes to any other address leave the queue and the status unchanged.
- R3: The captured lanes are `host_be` ANDed with a size window that starts at lane `host_addr[1:0]` and is 1 lane wide for size 0, 2 lanes for size 1, and 4 lanes for sizes 2 and 3. The window is clipped at lane 3. If the result has no lanes set, nothing is captured.
- R4: The captured bytes enter the queue lowest lane first, in one cycle, in consecutive slots. The sequence code is 00 for a lone byte, 01 for the first byte of a multi-byte write, 10 for a middle byte and 11 for the last byte.
- R5: The queue holds 32 records in arrival order. `dattr` shows the head record, or 0 when the queue is empty. `rd_en` pops the head. `rd_en` on an empty queue has no effect.
- R6: `status` bit 0 is not-empty, bit 1 is overrun, and bit 2 is 1 when the fill count is at or above `cfg_thresh`. All three follow the state after the most recent clock edge.
- R7: The status snapshot stored in a record is the `status` value seen in the cycle in which the write is presented.
- R8: Bytes that do not fit in the free space are dropped, while the earlier bytes of the same write are kept. Any dropped byte sets overrun on the next edge. Overrun stays set until a `clr_ovr` pulse clears it, and a new drop in the same cycle as the clear takes priority.
- R9: `irq` equals `cfg_irq_en` AND (count >= `cfg_thresh`).
- R10: A pop in the same cycle as a write does not create room for that write. Free space is the count before the edge subtracted from 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 16 | Host I/O address |
| host_data | input | 32 | Host write data, lane n in bits [8n+7:8n] |
| host_be | input | 4 | Host byte enables |
| host_size | input | 2 | Access size: 0 byte, 1 word, 2/3 dword |
| rd_en | input | 1 | Pop the head record |
| clr_ovr | input | 1 | Pulse that clears the overrun flag |
| cfg_thresh | input | 6 | Fill-level threshold |
| cfg_irq_en | input | 1 | Interrupt enable |
| dattr | output | 16 | Head record, or 0 when empty |
| status | output | 3 | {level reached, overrun, not empty} |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps every combination of start lane, size and byte enable, then drains each result. A design that ignored the size window, pushed lanes out of order or miscoded the first, middle or last position would show the wrong head record. Partial fits at 30 and 32 entries check that a write straddling the full boundary keeps exactly its leading bytes and raises overrun. A design that freed room using a same-cycle pop would instead keep a byte that should be dropped. The clear/drop collision and a threshold sweep from 0 to 33 catch a clear that beats a new drop, and an off-by-one in the level compare.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int LANES = 4;
  typedef logic [15:0] entry_t;

  // lanes reachable by an access of the given size starting at lane 'start'
  function automatic logic [3:0] size_mask(input logic [1:0] start, input logic [1:0] size);
    logic [7:0] m;
    case (size)
      2'd0:    m = 8'h01;
      2'd1:    m = 8'h03;
      default: m = 8'h0F;
    endcase
    m = m << start;
    return m[3:0];
  endfunction

  // position code of byte k among n captured bytes
  function automatic logic [1:0] seq_code(input logic [2:0] k, input logic [2:0] n);
    if (n == 3'd1)            return 2'b00;
    else if (k == 3'd0)       return 2'b01;
    else if (k == n - 3'd1)   return 2'b11;
    else                      return 2'b10;
  endfunction

  function automatic entry_t pack_entry(input logic [7:0] d, input logic [1:0] lane,
                                        input logic [1:0] code, input logic [2:0] snap);
    return {1'b0, snap, code, lane, d};
  endfunction
endpackage

// File: rtl/pc_lane_split.sv
module pc_lane_split
  import pc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h0080
) (
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [31:0]                 data,
  input  logic [LANES-1:0]            be,
  input  logic [1:0]                  size,
  input  logic [2:0]                  snap,
  output logic [LANES-1:0][15:0]      ent,
  output logic [2:0]                  n_bytes
);
  logic [LANES-1:0]      eff;
  logic                  hit;
  logic [2:0]            cnt;
  logic [LANES-1:0][1:0] lane_of;

  always_comb begin
    eff     = be & size_mask(addr[1:0], size);
    hit     = wr && (addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]) && (eff != '0);
    cnt     = '0;
    lane_of = '0;
    for (int l = 0; l < LANES; l++) begin
      if (eff[l]) begin
        lane_of[cnt[1:0]] = 2'(l);
        cnt = cnt + 3'd1;
      end
    end
    for (int k = 0; k < LANES; k++) begin
      ent[k] = pack_entry(data[{lane_of[k], 3'b000} +: 8], lane_of[k],
                          seq_code(3'(k), cnt), snap);
    end
    n_bytes = hit ? cnt : 3'd0;
  end
endmodule

// File: rtl/pc_fifo_mem.sv
module pc_fifo_mem
  import pc_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             n_push,
  input  logic [LANES-1:0][15:0] ent,
  input  logic                   pop,
  output logic [15:0]            head,
  output logic [CW-1:0]          count,
  output logic                   drop
);
  logic [15:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] free, want, acc;
  logic          pop_ok;

  always_comb begin
    free   = CW'(DEPTH) - count;
    want   = CW'(n_push);
    acc    = (want > free) ? free : want;
    drop   = want > free;
    pop_ok = pop && (count != '0);
    head   = (count != '0) ? mem[rp] : 16'h0000;
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++)
      if (CW'(k) < acc) mem[wp + AW'(k)] <= ent[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wp + acc[AW-1:0];
      rp    <= rp + AW'(pop_ok);
      count <= count + acc - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/postcode_fifo.sv
module postcode_fifo
  import pc_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h0080,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_data,
  input  logic [3:0]        host_be,
  input  logic [1:0]        host_size,
  input  logic              rd_en,
  input  logic              clr_ovr,
  input  logic [CW-1:0]     cfg_thresh,
  input  logic              cfg_irq_en,
  output logic [15:0]       dattr,
  output logic [2:0]        status,
  output logic              irq
);
  logic [LANES-1:0][15:0] ent;
  logic [2:0]             n_bytes;
  logic [CW-1:0]          count;
  logic                   ovr_evt;
  logic                   ovr_q;
  logic                   lvl;

  pc_lane_split #(.ADDR_W(ADDR_W), .BASE(BASE)) u_split (
    .wr(host_wr), .addr(host_addr), .data(host_data), .be(host_be),
    .size(host_size), .snap(status), .ent(ent), .n_bytes(n_bytes)
  );

  pc_fifo_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .n_push(n_bytes), .ent(ent), .pop(rd_en),
    .head(dattr), .count(count), .drop(ovr_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          ovr_q <= 1'b0;
    else if (ovr_evt)    ovr_q <= 1'b1;
    else if (clr_ovr)    ovr_q <= 1'b0;
  end

  always_comb begin
    lvl    = count >= cfg_thresh;
    status = {lvl, ovr_q, count != '0};
    irq    = cfg_irq_en && lvl;
  end
endmodule

module pc_chk #(
  parameter int DEPTH = 32,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count,
  input logic [2:0]    status,
  input logic [15:0]   dattr,
  input logic          irq,
  input logic          ovr_evt,
  input logic          clr_ovr,
  input logic          cfg_irq_en
);
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r5_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] |-> dattr == 16'h0000);
  a_r1_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dattr[15] == 1'b0);
  a_r8_drop_sets_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> status[1]);
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] && !clr_ovr |=> status[1]);
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |-> !irq);
endmodule

bind postcode_fifo pc_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .status(status), .dattr(dattr),
  .irq(irq), .ovr_evt(ovr_evt), .clr_ovr(clr_ovr), .cfg_irq_en(cfg_irq_en)
);

// File: tb/sim_postcode_fifo.sv
`timescale 1ns/1ps
module sim_postcode_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_addr = '0;
  logic [31:0] host_data = '0;
  logic [3:0]  host_be = '0;
  logic [1:0]  host_size = '0;
  logic        rd_en = 1'b0;
  logic        clr_ovr = 1'b0;
  logic [5:0]  cfg_thresh = 6'd3;
  logic        cfg_irq_en = 1'b1;
  logic [15:0] dattr;
  logic [2:0]  status;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [15:0] mq[$];
  logic        movr = 1'b0;

  always #2.5 clk = ~clk;

  postcode_fifo u0 (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [2:0] mstat();
    int c = mq.size();
    return {c >= int'(cfg_thresh), movr, c != 0};
  endfunction

  task automatic compare(input string tag);
    chk({tag, " R5 dattr"}, 32'(dattr), 32'((mq.size() != 0) ? mq[0] : 16'h0));
    chk({tag, " R6 status"}, 32'(status), 32'(mstat()));
    chk({tag, " R9 irq"}, 32'(irq), 32'(cfg_irq_en && (mq.size() >= int'(cfg_thresh))));
  endtask

  // model of one cycle: optional write, optional pop, optional clear
  task automatic cycle(input logic wr, input logic [15:0] a, input logic [31:0] d,
                       input logic [3:0] be, input logic [1:0] sz,
                       input logic pop, input logic clr, input string tag);
    int lanes[$];
    int width, had, room;
    logic [2:0] snap;
    logic dropped = 1'b0;
    @(negedge clk);
    host_wr = wr; host_addr = a; host_data = d; host_be = be; host_size = sz;
    rd_en = pop; clr_ovr = clr;
    snap = mstat();
    width = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (wr && a[15:2] == 14'h0020)
      for (int l = int'(a[1:0]); l < int'(a[1:0]) + width && l < 4; l++)
        if (be[l]) lanes.push_back(l);
    had  = mq.size();
    room = 32 - had;
    if (pop && had > 0) void'(mq.pop_front());
    foreach (lanes[i]) begin
      logic [1:0] code;
      if (lanes.size() == 1) code = 2'b00;
      else if (i == 0) code = 2'b01;
      else if (i == lanes.size() - 1) code = 2'b11;
      else code = 2'b10;
      if (i < room) mq.push_back({1'b0, snap, code, 2'(lanes[i]), d[8*lanes[i] +: 8]});
      else dropped = 1'b1;
    end
    if (dropped) movr = 1'b1;
    else if (clr) movr = 1'b0;
    @(negedge clk);
    host_wr = 0; rd_en = 0; clr_ovr = 0;
    compare(tag);
  endtask

  task automatic drain(input string tag);
    while (mq.size() != 0) cycle(0, 16'h0, 0, 0, 0, 1, 0, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("reset R6");

    // R1 R3 R4 R7: full sweep of start lane, size and enables
    for (int s = 0; s < 4; s++)
      for (int z = 0; z < 4; z++)
        for (int b = 0; b < 16; b++) begin
          cycle(1, 16'h0080 | 16'(s), 32'hA0B1C2D3 ^ 32'(b * 16 + z * 4 + s), 4'(b), 2'(z), 0, 0, "R3 R4 sweep");
          drain("R1 R4 drain");
        end

    // R2: other addresses are ignored
    cycle(1, 16'h0084, 32'h11223344, 4'hF, 2'd2, 0, 0, "R2 addr 84");
    cycle(1, 16'h0040, 32'h11223344, 4'hF, 2'd2, 0, 0, "R2 addr 40");
    cycle(0, 16'h0080, 32'h11223344, 4'hF, 2'd2, 0, 0, "R2 no strobe");

    // R5: pop when empty
    cycle(0, 16'h0, 0, 0, 0, 1, 0, "R5 empty pop");

    // R8: partial fit at 30 entries, then full
    for (int i = 0; i < 30; i++) cycle(1, 16'h0080, 32'(i), 4'h1, 2'd0, 0, 0, "R8 fill");
    cycle(1, 16'h0080, 32'hDEADBEEF, 4'hF, 2'd2, 0, 0, "R8 partial fit");
    cycle(1, 16'h0081, 32'h00005500, 4'h2, 2'd0, 0, 0, "R8 full drop");
    repeat (3) cycle(0, 16'h0, 0, 0, 0, 0, 0, "R8 sticky");
    // R10: pop and write together while full -> byte dropped
    cycle(0, 16'h0, 0, 0, 0, 0, 1, "R8 clear");
    cycle(1, 16'h0080, 32'h77, 4'h1, 2'd0, 1, 0, "R10 pop no room");
    // R8: clear collides with a drop, drop wins
    cycle(0, 16'h0, 0, 0, 0, 0, 1, "R8 clear2");
    cycle(1, 16'h0080, 32'h0000AA99, 4'h3, 2'd1, 0, 1, "R8 clear vs drop");
    cycle(0, 16'h0, 0, 0, 0, 0, 1, "R8 clear3");
    drain("R8 drain order");
    // R10: push and pop together with room
    cycle(1, 16'h0080, 32'h0302_0100, 4'h3, 2'd1, 0, 0, "R10 prep");
    cycle(1, 16'h0082, 32'h0504_0000, 4'hC, 2'd1, 1, 0, "R10 push+pop");
    drain("R10 drain");

    // R6 R9: threshold sweep over fill levels
    for (int t = 0; t < 34; t++) begin
      cfg_thresh = 6'(t);
      cfg_irq_en = t[0];
      for (int i = 0; i < 33; i++) cycle(1, 16'h0083, 32'(i) << 24, 4'h8, 2'd0, 0, 0, "R9 level");
      cycle(0, 16'h0, 0, 0, 0, 0, 1, "R9 clr");
      drain("R9 drain");
    end

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired got=hang exp=done");
    summary();
    $finish;
  end
endmodule